// File: doc/BRIEF.md
# Indirect Control/Status Register Front End

This block is the host-facing register front end of a small network controller. The host never addresses the control/status registers (CSRs) directly. It first writes a register number into a pointer port. It then reads or writes that register through a data port. A third port resets the whole block when it is read. A fourth port is decoded as bus-configuration data; it reads 0 and ignores writes. The port offsets come in two layouts. In the wide layout the ports sit on 4-byte strides. In the narrow layout the offsets at and above 0x10 are squeezed onto 2-byte strides.

The main register (number 0) holds the run-control commands, the interrupt enable, the event flags and two summary bits that are derived from the flags. A run-control state machine has four states: STOPPED, INITIALIZING, READY and RUNNING. It decides which command bits read back as set and drives the transmit/receive enables. The state machine takes these transitions:

- A stop command moves any state to STOPPED.
- Otherwise, a start command moves any state to RUNNING.
- Otherwise, an init command moves STOPPED, READY or RUNNING to INITIALIZING and emits an init request strobe.
- A done pulse from the initialisation engine moves INITIALIZING to READY.

Event pulses from the transmit and receive engines set sticky flags. Software clears a flag by writing 1 to its bit. A mask register selects which flags raise the interrupt line. Other registers hold the base address of the initialisation block, a few transmit and receive feature enables, and a read-only chip identifier.

Top module: `csr_front_end`

## Requirements
- R1: Port decode. When `wide_mode`=1, offsets 0x10, 0x14, 0x18 and 0x1C select the data, pointer, reset and bus-configuration ports. When `wide_mode`=0, the offset maps to (offset-0x10)/2+0x10, so 0x10, 0x12, 0x14 and 0x16 select the same four ports. The pointer port reads back the pointer value. The bus-configuration port and every other offset read 0 and ignore writes.
- R2: An asynchronous reset, or any read of the reset port, clears the block. Afterwards the pointer is 0, register 0 reads 0x0004 (only stop set) and every other register reads 0. The read of the reset port itself returns 0.
- R3: Run control. In a write to register 0, bit 2 (stop) has priority over bit 1 (start), and bit 1 has priority over bit 0 (init). While RUNNING, bit 1, bit 4 and bit 5 read 1, and `tx_enable` and `rx_enable` are 1. While STOPPED, bit 2 reads 1 and both enables are 0.
- R4: Writing bit 0 of register 0 in any state other than INITIALIZING enters INITIALIZING. Bit 0 then reads 1 and `init_req` is high for exactly one cycle. `evt_init_done` in INITIALIZING moves to READY and sets flag bit 8. In any other state `evt_init_done` is ignored.
- R5: Writing bit 3 of register 0 makes `tx_demand` high for exactly the following cycle. Bit 3 always reads 0.
- R6: The flags in bits 8 to 14 of register 0 are set by their events: init done, `evt_tx_done`, `evt_rx_done`, `evt_mem_err`, `evt_missed`, `evt_collision` and `evt_tx_timeout`, in that bit order. Writing 1 to a flag bit clears it and writing 0 leaves it. An event in the same cycle as the clear of that flag leaves the flag set.
- R7: Bit 15 of register 0 reads the OR of bits 11 to 14.
- R8: Bit 7 of register 0 is the OR of the flags in bits 8, 9, 10, 11, 12 and 14 whose mask bit in register 3 (same bit position) is 0. Bit 6 is a plain read/write interrupt enable. `irq` = bit 7 AND bit 6.
- R9: Registers 1 and 2 hold the low and high 16 bits of `init_base`.
- R10: Register 3 stores bits 2 to 5 (byte swap, alternate back-off, two-part deferral off, look-ahead, driving `swap_bytes`, `alt_backoff`, `no_defer2`, `lookahead`) and mask bits 8 to 12 and 14, and reads other bits as 0 (write 0xFFFF reads 0x5F3C). Register 4 bit 11 drives `auto_pad` and register 15 bit 15 drives `promiscuous`; their other bits read 0. Unimplemented registers read 0.
- R11: Register 88 reads CHIP_ID[15:0] and register 89 reads CHIP_ID[27:16] (default CHIP_ID is 0x5A3C001). Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects the 4-byte port layout, 0 selects the 2-byte layout |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and state |
| evt_init_done | input | 1 | Initialisation engine finished |
| evt_tx_done | input | 1 | Frame transmitted |
| evt_rx_done | input | 1 | Frame received |
| evt_mem_err | input | 1 | Memory access error |
| evt_missed | input | 1 | Receive frame dropped |
| evt_collision | input | 1 | Collision error |
| evt_tx_timeout | input | 1 | Transmitter ran too long |
| irq | output | 1 | Interrupt request |
| init_req | output | 1 | One-cycle request to start initialisation |
| tx_demand | output | 1 | One-cycle transmit poll strobe |
| tx_enable | output | 1 | Transmitter on |
| rx_enable | output | 1 | Receiver on |
| init_base | output | 32 | Initialisation block address |
| swap_bytes | output | 1 | Byte swap enable |
| alt_backoff | output | 1 | Alternate back-off enable |
| no_defer2 | output | 1 | Two-part deferral disable |
| lookahead | output | 1 | Look-ahead processing enable |
| auto_pad | output | 1 | Short transmit frame padding enable |
| promiscuous | output | 1 | Accept all frames |

## Verification
The bench targets the moments where two sources act on one bit in the same cycle. An event that arrives together with a write-1 clear must leave the flag set; a design with the wrong order would lose an interrupt. A write carrying stop together with start, or start together with init, must resolve by priority; a wrong priority would leave the transmitter running after a stop. The bench also checks the derived bits. The collision flag must raise bit 15 but not the interrupt, masking an already-set flag must drop `irq`, and an init done pulse outside INITIALIZING must not set bit 8. Finally the bench repeats accesses in the narrow layout. A decoder that ignored the mode would treat a read of offset 0x14 as a pointer read instead of a reset, and would leave the state intact.

// File: rtl/csr_fe_pkg.sv
package csr_fe_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED      = 2'd0,
        ST_INITIALIZING = 2'd1,
        ST_READY        = 2'd2,
        ST_RUNNING      = 2'd3
    } run_state_t;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_DATA,
        PORT_PTR,
        PORT_RESET,
        PORT_BCFG
    } port_sel_t;

    localparam int REG_W     = 16;
    localparam int PORT_BASE = 16;

    // event flags occupy main register bits FLAG_LSB .. FLAG_LSB+NUM_FLAGS-1
    localparam int NUM_FLAGS = 7;
    localparam int FLAG_LSB  = 8;
    localparam int F_MERR    = 3;
    localparam int F_BABL    = 6;
    localparam int F_CERR    = 5;

    // collision flag never raises the interrupt summary
    localparam logic [NUM_FLAGS-1:0] IRQ_SOURCES = 7'b1011111;
    localparam logic [REG_W-1:0]     MASKREG_KEEP = 16'h5F3C;

    localparam int CSR_MAIN    = 0;
    localparam int CSR_BASE_LO = 1;
    localparam int CSR_BASE_HI = 2;
    localparam int CSR_MASK    = 3;
    localparam int CSR_FEAT    = 4;
    localparam int CSR_MODE    = 15;
    localparam int CSR_ID_LO   = 88;
    localparam int CSR_ID_HI   = 89;

    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_IENA  = 6;
    localparam int B_PAD   = 11;
    localparam int B_PROM  = 15;

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode
    import csr_fe_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    output port_sel_t         port
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;
    logic              aligned;

    always_comb begin
        rel = addr - ADDR_W'(PORT_BASE);
        if (wide_mode) begin
            aligned = (rel[1:0] == 2'b00);
            idx     = rel >> 2;
        end else begin
            aligned = !rel[0];
            idx     = rel >> 1;
        end
        port = PORT_NONE;
        if (addr >= ADDR_W'(PORT_BASE) && aligned) begin
            case (int'(idx))
                0:       port = PORT_DATA;
                1:       port = PORT_PTR;
                2:       port = PORT_RESET;
                3:       port = PORT_BCFG;
                default: port = PORT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/csr_run_fsm.sv
module csr_run_fsm
    import csr_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       cmd_init,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       init_done_evt,
    output run_state_t state,
    output logic       init_done_ok,
    output logic       init_req,
    output logic       tx_en,
    output logic       rx_en
);

    run_state_t nxt;

    always_comb begin
        nxt = state;
        if (cmd_stop) begin
            nxt = ST_STOPPED;
        end else if (cmd_start) begin
            nxt = ST_RUNNING;
        end else begin
            unique case (state)
                ST_INITIALIZING: if (init_done_evt) nxt = ST_READY;
                ST_STOPPED,
                ST_READY,
                ST_RUNNING:      if (cmd_init) nxt = ST_INITIALIZING;
                default:         nxt = state;
            endcase
        end
    end

    assign init_done_ok = (state == ST_INITIALIZING) && init_done_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOPPED;
        end else if (sw_rst) begin
            state <= ST_STOPPED;
        end else begin
            state <= nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_req <= 1'b0;
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
        end else if (sw_rst) begin
            init_req <= 1'b0;
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
        end else begin
            init_req <= (nxt == ST_INITIALIZING) && (state != ST_INITIALIZING);
            tx_en    <= (nxt == ST_RUNNING);
            rx_en    <= (nxt == ST_RUNNING);
        end
    end

    AST_INIT_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !init_req) else $error("init_req longer than one cycle"); // R4
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !sw_rst) |=> (state == ST_STOPPED && !tx_en && !rx_en)) else $error("stop not obeyed"); // R3
    AST_SWRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (state == ST_STOPPED && !init_req)) else $error("software reset missed"); // R2

endmodule

// File: rtl/csr_event_flags.sv
module csr_event_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[k] <= 1'b0;
            end else if (sw_rst) begin
                flags[k] <= 1'b0;
            end else if (set_vec[k]) begin
                flags[k] <= 1'b1;
            end else if (clr_vec[k]) begin
                flags[k] <= 1'b0;
            end
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && !sw_rst) |=> ((flags & $past(set_vec)) == $past(set_vec)))
        else $error("event lost"); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((flags & ~$past(flags)) == '0))
        else $error("flag rose without event"); // R6

endmodule

// File: rtl/csr_front_end.sv
module csr_front_end
    import csr_fe_pkg::*;
#(
    parameter int          ADDR_W  = 5,
    parameter int          PTR_W   = 8,
    parameter logic [27:0] CHIP_ID = 28'h5A3C001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              evt_init_done,
    input  logic              evt_tx_done,
    input  logic              evt_rx_done,
    input  logic              evt_mem_err,
    input  logic              evt_missed,
    input  logic              evt_collision,
    input  logic              evt_tx_timeout,
    output logic              irq,
    output logic              init_req,
    output logic              tx_demand,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic [31:0]       init_base,
    output logic              swap_bytes,
    output logic              alt_backoff,
    output logic              no_defer2,
    output logic              lookahead,
    output logic              auto_pad,
    output logic              promiscuous
);

    port_sel_t            port;
    run_state_t           run_state;
    logic [PTR_W-1:0]     ptr;
    logic                 iena;
    logic [REG_W-1:0]     base_lo;
    logic [REG_W-1:0]     base_hi;
    logic [REG_W-1:0]     mask_reg;
    logic                 pad_en;
    logic                 prom_en;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_mask;
    logic                 init_done_ok;
    logic                 rd_access, wr_access, sw_rst, ptr_wr, data_wr, wr_main;
    logic                 intr_sum, err_sum;
    logic [REG_W-1:0]     main_val;
    logic [REG_W-1:0]     csr_val;

    csr_port_decode #(.ADDR_W(ADDR_W)) i_decode (
        .wide_mode (wide_mode),
        .addr      (bus_addr),
        .port      (port)
    );

    assign rd_access = bus_sel && !bus_we;
    assign wr_access = bus_sel && bus_we;
    assign sw_rst    = rd_access && (port == PORT_RESET);
    assign ptr_wr    = wr_access && (port == PORT_PTR);
    assign data_wr   = wr_access && (port == PORT_DATA);
    assign wr_main   = data_wr && (int'(ptr) == CSR_MAIN);

    csr_run_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_rst        (sw_rst),
        .cmd_init      (wr_main && bus_wdata[B_INIT]),
        .cmd_start     (wr_main && bus_wdata[B_START]),
        .cmd_stop      (wr_main && bus_wdata[B_STOP]),
        .init_done_evt (evt_init_done),
        .state         (run_state),
        .init_done_ok  (init_done_ok),
        .init_req      (init_req),
        .tx_en         (tx_enable),
        .rx_en         (rx_enable)
    );

    assign set_vec = {evt_tx_timeout, evt_collision, evt_missed, evt_mem_err,
                      evt_rx_done, evt_tx_done, init_done_ok};
    assign clr_vec = wr_main ? bus_wdata[FLAG_LSB +: NUM_FLAGS] : '0;

    csr_event_flags #(.N(NUM_FLAGS)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    // pointer, enables and plain storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            iena      <= 1'b0;
            base_lo   <= '0;
            base_hi   <= '0;
            mask_reg  <= '0;
            pad_en    <= 1'b0;
            prom_en   <= 1'b0;
            tx_demand <= 1'b0;
        end else if (sw_rst) begin
            ptr       <= '0;
            iena      <= 1'b0;
            base_lo   <= '0;
            base_hi   <= '0;
            mask_reg  <= '0;
            pad_en    <= 1'b0;
            prom_en   <= 1'b0;
            tx_demand <= 1'b0;
        end else begin
            tx_demand <= wr_main && bus_wdata[B_TDMD];
            if (ptr_wr) begin
                ptr <= bus_wdata[PTR_W-1:0];
            end
            if (wr_main) begin
                iena <= bus_wdata[B_IENA];
            end
            if (data_wr) begin
                case (int'(ptr))
                    CSR_BASE_LO: base_lo  <= bus_wdata;
                    CSR_BASE_HI: base_hi  <= bus_wdata;
                    CSR_MASK:    mask_reg <= bus_wdata & MASKREG_KEEP;
                    CSR_FEAT:    pad_en   <= bus_wdata[B_PAD];
                    CSR_MODE:    prom_en  <= bus_wdata[B_PROM];
                    default:     ;
                endcase
            end
        end
    end

    assign flag_mask = mask_reg[FLAG_LSB +: NUM_FLAGS];
    assign intr_sum  = |(flags & IRQ_SOURCES & ~flag_mask);
    assign err_sum   = |flags[F_BABL:F_MERR];
    assign irq       = intr_sum && iena;

    assign main_val = {err_sum, flags, intr_sum, iena, rx_enable, tx_enable, 1'b0,
                       run_state == ST_STOPPED, run_state == ST_RUNNING,
                       run_state == ST_INITIALIZING};

    always_comb begin
        case (int'(ptr))
            CSR_MAIN:    csr_val = main_val;
            CSR_BASE_LO: csr_val = base_lo;
            CSR_BASE_HI: csr_val = base_hi;
            CSR_MASK:    csr_val = mask_reg;
            CSR_FEAT:    csr_val = REG_W'(pad_en) << B_PAD;
            CSR_MODE:    csr_val = REG_W'(prom_en) << B_PROM;
            CSR_ID_LO:   csr_val = CHIP_ID[15:0];
            CSR_ID_HI:   csr_val = {4'h0, CHIP_ID[27:16]};
            default:     csr_val = '0;
        endcase
    end

    always_comb begin
        case (port)
            PORT_DATA: bus_rdata = csr_val;
            PORT_PTR:  bus_rdata = REG_W'(ptr);
            default:   bus_rdata = '0;
        endcase
    end

    assign init_base   = {base_hi, base_lo};
    assign swap_bytes  = mask_reg[2];
    assign alt_backoff = mask_reg[3];
    assign no_defer2   = mask_reg[4];
    assign lookahead   = mask_reg[5];
    assign auto_pad    = pad_en;
    assign promiscuous = prom_en;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & IRQ_SOURCES) != '0)) else $error("irq without flag"); // R8
    AST_CERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & IRQ_SOURCES) == '0) |-> !irq) else $error("collision raised irq"); // R8

endmodule

// File: tb/test_csr_front_end.sv
`timescale 1ns/100ps
module test_csr_front_end;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, wide_mode, bus_sel, bus_we;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        evt_init_done, evt_tx_done, evt_rx_done, evt_mem_err;
    logic        evt_missed, evt_collision, evt_tx_timeout;
    logic        irq, init_req, tx_demand, tx_enable, rx_enable;
    logic [31:0] init_base;
    logic        swap_bytes, alt_backoff, no_defer2, lookahead, auto_pad, promiscuous;

    csr_front_end i_csr_front_end (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_st;    // 0 stopped, 1 initializing, 2 ready, 3 running
    bit         m_iena, m_pad, m_prom, m_ireq, m_tdm;
    bit [6:0]   m_fl;
    bit [15:0]  m_r3, m_lo, m_hi;
    int         m_ptr;

    function automatic int exp_port(bit wide, logic [4:0] a);
        if (wide) begin
            case (a) 5'h10: return 1; 5'h14: return 2; 5'h18: return 3; 5'h1C: return 4; default: return 0; endcase
        end
        case (a) 5'h10: return 1; 5'h12: return 2; 5'h14: return 3; 5'h16: return 4; default: return 0; endcase
    endfunction

    function automatic bit m_intr();
        bit [6:0] live = m_fl & ~{m_r3[14], 1'b0, m_r3[12:8]};
        return (live[0] | live[1] | live[2] | live[3] | live[4] | live[6]);
    endfunction

    function automatic logic [15:0] m_read(int n);
        logic [15:0] v;
        case (n)
            0: begin
                v = 16'h0;
                v[15]   = m_fl[3] | m_fl[4] | m_fl[5] | m_fl[6];
                v[14:8] = m_fl;
                v[7]    = m_intr();
                v[6]    = m_iena;
                v[5]    = (m_st == 3);
                v[4]    = (m_st == 3);
                v[2]    = (m_st == 0);
                v[1]    = (m_st == 3);
                v[0]    = (m_st == 1);
            end
            1:  v = m_lo;
            2:  v = m_hi;
            3:  v = m_r3;
            4:  v = m_pad ? 16'h0800 : 16'h0;
            15: v = m_prom ? 16'h8000 : 16'h0;
            88: v = 16'hC001;
            89: v = 16'h05A3;
            default: v = 16'h0;
        endcase
        return v;
    endfunction

    task automatic m_clear();
        m_st = 0; m_iena = 0; m_pad = 0; m_prom = 0; m_ireq = 0; m_tdm = 0;
        m_fl = 0; m_r3 = 0; m_lo = 0; m_hi = 0; m_ptr = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_clear();
        end else begin
            int p, nst;
            bit mw;
            bit [6:0] evs;
            p = exp_port(wide_mode, bus_addr);
            if (bus_sel && !bus_we && p == 3) begin
                m_clear();
            end else begin
                mw  = bus_sel && bus_we && p == 1 && m_ptr == 0;
                evs = {evt_tx_timeout, evt_collision, evt_missed, evt_mem_err,
                       evt_rx_done, evt_tx_done, (m_st == 1) && evt_init_done};
                m_fl = (m_fl & ~(mw ? bus_wdata[14:8] : 7'h0)) | evs;
                nst = m_st;
                if (mw && bus_wdata[2])      nst = 0;
                else if (mw && bus_wdata[1]) nst = 3;
                else if (m_st == 1) begin
                    if (evt_init_done) nst = 2;
                end else if (mw && bus_wdata[0]) nst = 1;
                m_ireq = (nst == 1) && (m_st != 1);
                m_tdm  = mw && bus_wdata[3];
                if (mw) m_iena = bus_wdata[6];
                if (bus_sel && bus_we && p == 1) begin
                    case (m_ptr)
                        1:  m_lo = bus_wdata;
                        2:  m_hi = bus_wdata;
                        3:  m_r3 = bus_wdata & 16'h5F3C;
                        4:  m_pad = bus_wdata[11];
                        15: m_prom = bus_wdata[15];
                        default: ;
                    endcase
                end
                if (bus_sel && bus_we && p == 2) m_ptr = int'(bus_wdata[7:0]);
                m_st = nst;
            end
        end
    end

    // every-clock comparison of the registered outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 irq",        irq,       m_iena && m_intr());
            chk("R3 tx_enable",  tx_enable, m_st == 3);
            chk("R3 rx_enable",  rx_enable, m_st == 3);
            chk("R4 init_req",   init_req,  m_ireq);
            chk("R5 tx_demand",  tx_demand, m_tdm);
            chk("R9 init_base",  init_base, {m_hi, m_lo});
            chk("R10 features",  {promiscuous, auto_pad, lookahead, no_defer2, alt_backoff, swap_bytes},
                                 {m_prom, m_pad, m_r3[5], m_r3[4], m_r3[3], m_r3[2]});
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [4:0] a_data, a_ptr, a_rst;

    task automatic idle();
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        {evt_tx_timeout, evt_collision, evt_missed, evt_mem_err, evt_rx_done, evt_tx_done, evt_init_done} = '0;
    endtask

    task automatic cyc(input bit s, input bit w, input logic [4:0] a, input logic [15:0] d, input logic [6:0] ev);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        {evt_tx_timeout, evt_collision, evt_missed, evt_mem_err, evt_rx_done, evt_tx_done, evt_init_done} = ev;
        @(posedge clk);
        #1 idle();
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        int p;
        logic [15:0] mexp, v;
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 v = bus_rdata;
        p = exp_port(wide_mode, a);
        mexp = (p == 1) ? m_read(m_ptr) : (p == 2) ? 16'(m_ptr) : 16'h0;
        chk({tag, " model"}, v, mexp);
        chk(tag, v, exp);
        @(posedge clk);
        #1 idle();
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        cyc(1, 1, a, d, 7'h0);
    endtask

    task automatic ev(input logic [6:0] e);
        cyc(0, 0, 5'h0, 16'h0, e);
    endtask

    task automatic csrw(input int n, input logic [15:0] d);
        wr(a_ptr, 16'(n));
        wr(a_data, d);
    endtask

    task automatic csrr(input int n, input logic [15:0] exp, input string tag);
        wr(a_ptr, 16'(n));
        rd(a_data, exp, tag);
    endtask

    // event vector order: {timeout, collision, missed, mem_err, rx, tx, init_done}
    localparam logic [6:0] E_IDON = 7'h01, E_TX = 7'h02, E_RX = 7'h04, E_MERR = 7'h08, E_CERR = 7'h20;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0; wide_mode = 1;
        a_data = 5'h10; a_ptr = 5'h14; a_rst = 5'h18;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        rd(a_ptr, 16'h0000, "R2 pointer after reset");
        rd(a_data, 16'h0004, "R2 main after reset");
        chk("R2 irq after reset", irq, 1'b0);

        // R10 mask and features
        csrw(3, 16'h013C);
        csrr(3, 16'h013C, "R10 mask readback");
        chk("R10 swap_bytes", swap_bytes, 1'b1);

        // R9 base address
        csrw(1, 16'h1234);
        csrw(2, 16'hABCD);
        chk("R9 init_base", init_base, 32'hABCD1234);
        csrr(2, 16'hABCD, "R9 high half");

        // R4 initialisation
        csrw(0, 16'h0001);
        chk("R4 init_req strobe", init_req, 1'b1);
        @(posedge clk); #1 chk("R4 init_req one cycle", init_req, 1'b0);
        csrr(0, 16'h0001, "R4 init bit while initializing");
        ev(E_IDON);
        csrr(0, 16'h0100, "R4 done flag, masked so no summary");

        // R3 start with enable
        csrw(0, 16'h0142);
        csrr(0, 16'h0072, "R3 running");
        chk("R3 tx_enable", tx_enable, 1'b1);

        // R6 R8 events
        ev(E_RX);
        csrr(0, 16'h04F2, "R6 receive flag set");
        chk("R8 irq raised", irq, 1'b1);
        ev(E_MERR);
        csrr(0, 16'h8CF2, "R7 error summary");
        cyc(1, 1, a_data, 16'h0440, E_TX);
        csrr(0, 16'h8AF2, "R6 clear rx while tx arrives");
        cyc(1, 1, a_data, 16'h0A40, E_TX);
        csrr(0, 16'h02F2, "R6 event beats clear");
        wr(a_data, 16'h0040);
        csrr(0, 16'h02F2, "R6 write zero keeps flags");
        wr(a_data, 16'h0240);
        csrr(0, 16'h0072, "R6 clear tx flag");
        chk("R8 irq dropped", irq, 1'b0);
        ev(E_CERR);
        csrr(0, 16'hA072, "R7 collision sets summary");
        chk("R8 collision no irq", irq, 1'b0);
        wr(a_data, 16'h2000);
        csrr(0, 16'h0032, "R8 enable cleared");
        ev(E_TX);
        csrr(0, 16'h02B2, "R8 summary without enable");
        chk("R8 irq gated", irq, 1'b0);

        // R5 transmit demand
        wr(a_data, 16'h0008);
        chk("R5 tx_demand strobe", tx_demand, 1'b1);
        @(posedge clk); #1 chk("R5 tx_demand one cycle", tx_demand, 1'b0);
        rd(a_data, 16'h02B2, "R5 demand reads zero");

        // R3 priorities
        wr(a_data, 16'h0004);
        rd(a_data, 16'h0284, "R3 stopped");
        chk("R3 rx_enable off", rx_enable, 1'b0);
        wr(a_data, 16'h0007);
        chk("R3 stop over init", init_req, 1'b0);
        rd(a_data, 16'h0284, "R3 stop wins");
        wr(a_data, 16'h0003);
        chk("R3 start over init", init_req, 1'b0);
        rd(a_data, 16'h02B2, "R3 start wins");
        ev(E_IDON);
        rd(a_data, 16'h02B2, "R4 done ignored when running");

        // R8 R10 masking a live flag
        csrw(3, 16'hFFFF);
        csrr(3, 16'h5F3C, "R10 mask keeps defined bits");
        csrr(0, 16'h0232, "R8 masked flag drops summary");
        csrw(4, 16'hFFFF);
        csrr(4, 16'h0800, "R10 auto pad register");
        chk("R10 auto_pad", auto_pad, 1'b1);
        csrw(15, 16'hFFFF);
        csrr(15, 16'h8000, "R10 promiscuous register");
        chk("R10 promiscuous", promiscuous, 1'b1);
        csrr(7, 16'h0000, "R10 unimplemented register");

        // R11 identifier
        csrr(88, 16'hC001, "R11 id low");
        wr(a_data, 16'hFFFF);
        rd(a_data, 16'hC001, "R11 id low read-only");
        csrr(89, 16'h05A3, "R11 id high");

        // R1 wide decode
        rd(a_ptr, 16'h0059, "R1 pointer readback");
        rd(5'h1C, 16'h0000, "R1 bus config port");
        rd(5'h00, 16'h0000, "R1 low offset");

        // R2 software reset
        rd(a_rst, 16'h0000, "R2 reset port read");
        rd(a_ptr, 16'h0000, "R2 pointer cleared");
        rd(a_data, 16'h0004, "R2 main cleared");
        chk("R2 init_base cleared", init_base, 32'h0);
        chk("R2 promiscuous cleared", promiscuous, 1'b0);

        // R1 narrow layout
        wide_mode = 0;
        a_data = 5'h10; a_ptr = 5'h12; a_rst = 5'h14;
        csrw(1, 16'h5555);
        csrr(1, 16'h5555, "R1 narrow data port");
        rd(5'h18, 16'h0000, "R1 narrow unmapped offset");
        csrr(1, 16'h5555, "R1 narrow state kept");
        csrw(0, 16'h0002);
        chk("R1 narrow start", tx_enable, 1'b1);
        rd(a_rst, 16'h0000, "R1 narrow reset port");
        csrr(0, 16'h0004, "R2 narrow reset main");
        csrr(1, 16'h0000, "R2 narrow reset base");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule